// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the serial master for a 12-bit differential successive-approximation converter. On a start request it pulls the converter's chip select low. It then produces the serial clock from the system clock, using a programmable half-period divider, and samples the converter's data line on each rising serial-clock edge. The leading null bit is dropped. The next twelve bits, most significant first, form a two's-complement result, which is delivered with a one-cycle valid strobe at the moment chip select returns high.

The frame length is picked per frame from three settings (16, 15 or 14 rising edges). In mirror mode the controller instead keeps clocking until the converter has sent the word a second time, least significant bit first. It rebuilds that copy, compares it with the first one, and flags any difference alongside the result. A small averager after the frame logic adds 2^k consecutive results and emits their floor-mean, with k from 0 to 4.

The divider, frame-length code and mirror enable are sampled only when a frame starts. Start requests made while a frame or its closing gap is in progress have no effect.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select and the serial clock are high, and busy, res_valid, mirror_err and avg_valid are low.
- R2: A start request seen while idle drives chip select low on the next clock edge. While chip select is high the serial clock stays high, and the first serial-clock transition of a frame is a falling edge.
- R3: Every serial-clock half period lasts cfg_half_div+1 system clocks, and chip select stays low for exactly (2*N+1)*(cfg_half_div+1) system clocks, where N is the number of rising edges in the frame.
- R4: The number of rising serial-clock edges in a frame, N, is set by cfg_len: 0 or 3 gives 16, 1 gives 15, 2 gives 14. When cfg_mirror is 1, N is 24 whatever cfg_len holds.
- R5: Data is sampled on rising serial-clock edges. The bit at rising edge 1 is a null bit and is ignored. The bits at rising edges 2 to 13 are result bits 11 down to 0. res_data is two's complement, so 0x7FF is +2047 and 0x800 is -2048.
- R6: res_valid is a one-cycle pulse, raised in the same cycle that chip select returns high, and it carries the frame's result.
- R7: Once chip select rises, it stays high for at least two serial-clock half periods before the next frame. A start request held or repeated during a frame does not start a second frame.
- R8: In mirror mode, the bits at rising edges 13 to 24 are result bits 0 to 11. If this copy differs from the first word, mirror_err pulses together with res_valid. res_data always carries the first word.
- R9: The averager sums 2^k consecutive results, where k is cfg_avg_log2 sampled with the group's first result and values above 4 count as 4. One cycle after the group's last res_valid it pulses avg_valid, and avg_data holds floor(sum / 2^k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken only while idle |
| cfg_half_div | input | 8 | Serial-clock half period minus one, in system clocks |
| cfg_len | input | 2 | Frame length code |
| cfg_mirror | input | 1 | Enable capture and check of the repeated LSB-first word |
| cfg_avg_log2 | input | 3 | log2 of the averaging group size |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A frame or its closing gap is in progress |
| res_data | output | 12 | Signed conversion result |
| res_valid | output | 1 | One-cycle result strobe |
| mirror_err | output | 1 | Repeated word disagreed with the first word |
| avg_data | output | 12 | Signed mean of the last group |
| avg_valid | output | 1 | One-cycle mean strobe |

## Verification
A converter model in the bench answers each falling serial-clock edge with the next bit of a chosen code. A strided sweep of the whole 12-bit code space, plus the all-zero, all-one, alternating and full-scale codes, separates bit-order and sign mistakes from off-by-one sampling. Sending a null bit of 1 shows whether the controller stores the null bit. Mirror frames are run once with a faithful repeat and once with one flipped bit, which tells a working comparator from one that never or always fires. The divider and length codes are varied while the chip-select low time and the count of rising edges are measured. Mixed-sign groups check the averager's floor rounding and its clamp on the group size.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_CLOSE,
    ST_GAP
  } frame_st_e;

  // Rising serial-clock edges in one frame for a given length code.
  function automatic int unsigned frame_rises(input int unsigned len_code,
                                              input bit mirror_on,
                                              input int unsigned data_w);
    if (mirror_on) return 2 * data_w;
    case (len_code)
      1: return data_w + 3;
      2: return data_w + 2;
      default: return data_w + 4;
    endcase
  endfunction

endpackage

// File: rtl/adc_sclk_divider.sv
module adc_sclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  p_div_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= half_div));

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_mirror,
  input  logic              tick,
  input  logic              sdata,
  output logic [DIV_W-1:0]  div_q,
  output logic              run,
  output logic              cs_n,
  output logic              sclk,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              mirror_err
);

  localparam int MIR_LEN = 2 * DATA_W;
  localparam int IDX_W   = $clog2(MIR_LEN + 1);

  frame_st_e         state;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  len_q;
  logic              mir_on;
  logic              gap_half;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] mir_q;

  // Named internal events
  logic             rise_evt;
  logic             fall_evt;
  logic             last_rise;
  logic             in_word;
  logic             in_mirror;
  logic [IDX_W-1:0] mir_pos;

  assign run       = (state != ST_IDLE);
  assign rise_evt  = tick && (state == ST_RUN) && !sclk;
  assign fall_evt  = tick && (((state == ST_RUN) && sclk) || (state == ST_LEAD));
  assign last_rise = rise_evt && (bit_idx == len_q - IDX_W'(1));
  assign in_word   = (bit_idx >= IDX_W'(1)) && (bit_idx <= IDX_W'(DATA_W));
  assign in_mirror = mir_on && (bit_idx >= IDX_W'(DATA_W));
  assign mir_pos   = bit_idx - IDX_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      bit_idx    <= '0;
      len_q      <= '0;
      mir_on     <= 1'b0;
      gap_half   <= 1'b0;
      div_q      <= '0;
      word_q     <= '0;
      mir_q      <= '0;
      res_data   <= '0;
      res_valid  <= 1'b0;
      mirror_err <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      mirror_err <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LEAD;
          cs_n    <= 1'b0;
          div_q   <= cfg_half_div;
          len_q   <= IDX_W'(frame_rises(int'(cfg_len), cfg_mirror, DATA_W));
          mir_on  <= cfg_mirror;
          bit_idx <= '0;
        end
        ST_LEAD: if (tick) begin
          sclk  <= 1'b0;
          state <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (in_word) word_q <= {word_q[DATA_W-2:0], sdata};
            if (in_mirror) begin
              for (int i = 0; i < DATA_W; i++)
                if (mir_pos == IDX_W'(i)) mir_q[i] <= sdata;
            end
            if (last_rise) state <= ST_CLOSE;
            else           bit_idx <= bit_idx + 1'b1;
          end else begin
            sclk <= 1'b0;
          end
        end
        ST_CLOSE: if (tick) begin
          cs_n       <= 1'b1;
          res_valid  <= 1'b1;
          res_data   <= word_q;
          mirror_err <= mir_on && (mir_q != word_q);
          gap_half   <= 1'b0;
          state      <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          gap_half <= 1'b1;
          if (gap_half) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_sclk_high_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_first_edge_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);
  p_sclk_only_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk));
  p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !sclk);
  p_rise_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (bit_idx < len_q));
  p_valid_at_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_frame_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(state) == ST_IDLE));
  p_mirror_err_with_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_err |-> res_valid);

endmodule

// File: rtl/adc_result_avg.sv
module adc_result_avg #(
  parameter int DATA_W    = 12,
  parameter int MAX_LOG2  = 4,
  parameter int K_W       = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [K_W-1:0]           k_req,
  output logic signed [DATA_W-1:0] avg_data,
  output logic                     avg_valid
);

  localparam int ACC_W = DATA_W + MAX_LOG2;
  localparam int CNT_W = MAX_LOG2 + 1;

  function automatic logic [K_W-1:0] clamp_k(input logic [K_W-1:0] k);
    return (int'(k) > MAX_LOG2) ? K_W'(MAX_LOG2) : k;
  endfunction

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum_next;
  logic [CNT_W-1:0]        cnt;
  logic [K_W-1:0]          k_q;
  logic [K_W-1:0]          k_eff;
  logic                    group_end;

  assign k_eff     = (cnt == '0) ? clamp_k(k_req) : k_q;
  assign sum_next  = acc + ACC_W'(in_data);
  assign group_end = in_valid && (cnt == CNT_W'((1 << k_eff) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      k_q       <= '0;
      avg_data  <= '0;
      avg_valid <= 1'b0;
    end else begin
      avg_valid <= 1'b0;
      if (group_end) begin
        avg_data  <= DATA_W'(sum_next >>> k_eff);
        avg_valid <= 1'b1;
        acc       <= '0;
        cnt       <= '0;
      end else if (in_valid) begin
        acc <= sum_next;
        cnt <= cnt + 1'b1;
        k_q <= k_eff;
      end
    end
  end

  p_avg_follows_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> $past(in_valid));
  p_group_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < (1 << MAX_LOG2));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_W   = 12,
  parameter int DIV_W    = 8,
  parameter int MAX_LOG2 = 4,
  parameter int K_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_mirror,
  input  logic [K_W-1:0]    cfg_avg_log2,
  input  logic              adc_sdata,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              busy,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              mirror_err,
  output logic [DATA_W-1:0] avg_data,
  output logic              avg_valid
);

  logic             tick;
  logic             run;
  logic [DIV_W-1:0] div_q;

  assign busy = run;

  adc_sclk_divider #(.DIV_W(DIV_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_div (div_q),
    .tick     (tick)
  );

  adc_frame_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_half_div (cfg_half_div),
    .cfg_len      (cfg_len),
    .cfg_mirror   (cfg_mirror),
    .tick         (tick),
    .sdata        (adc_sdata),
    .div_q        (div_q),
    .run          (run),
    .cs_n         (adc_cs_n),
    .sclk         (adc_sclk),
    .res_data     (res_data),
    .res_valid    (res_valid),
    .mirror_err   (mirror_err)
  );

  adc_result_avg #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2), .K_W(K_W)) i_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (res_valid),
    .in_data   (res_data),
    .k_req     (cfg_avg_log2),
    .avg_data  (avg_data),
    .avg_valid (avg_valid)
  );

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cfg_half_div = 8'd0;
  logic [1:0]  cfg_len = 2'd0;
  logic        cfg_mirror = 1'b0;
  logic [2:0]  cfg_avg_log2 = 3'd0;
  logic        adc_sdata = 1'b0;
  logic        adc_cs_n, adc_sclk, busy, res_valid, mirror_err, avg_valid;
  logic [11:0] res_data, avg_data;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  // converter model
  logic [11:0] m_code = '0;
  logic        m_null = 1'b0;
  logic        m_corrupt = 1'b0;
  int          fidx = 0;
  int          rises = 0;
  int          clow = 0;
  int          chigh = 0;
  bit          res_seen = 1'b0;
  logic [11:0] got_res;
  logic        got_err;
  logic        cs_at_valid;
  int          avg_cnt = 0;
  logic [11:0] got_avg;

  always #5 clk = ~clk;

  adc_frame_reader i_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_half_div(cfg_half_div),
    .cfg_len(cfg_len), .cfg_mirror(cfg_mirror), .cfg_avg_log2(cfg_avg_log2),
    .adc_sdata(adc_sdata), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .busy(busy),
    .res_data(res_data), .res_valid(res_valid), .mirror_err(mirror_err),
    .avg_data(avg_data), .avg_valid(avg_valid)
  );

  function automatic logic model_bit(input int idx);
    if (idx == 0) return m_null;
    if (idx <= 12) return m_code[12 - idx];
    if (idx <= 23) return m_code[idx - 12] ^ (m_corrupt && idx == 18);
    return 1'b0;
  endfunction

  always @(negedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      fidx <= 0;
      adc_sdata <= 1'b0;
    end else begin
      adc_sdata <= model_bit(fidx);
      fidx <= fidx + 1;
    end
  end

  always @(posedge adc_sclk) if (!adc_cs_n) rises++;

  always @(negedge clk) begin
    if (!adc_cs_n) clow++;
    else chigh++;
    if (res_valid) begin
      res_seen = 1'b1;
      got_res = res_data;
      got_err = mirror_err;
      cs_at_valid = adc_cs_n;
    end
    if (avg_valid) begin
      avg_cnt++;
      got_avg = avg_data;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // One frame; start held for three cycles (extra cycles must be ignored)
  task automatic frame(input logic [11:0] code, input logic nullv, input logic corr);
    m_code = code; m_null = nullv; m_corrupt = corr;
    rises = 0; clow = 0; res_seen = 1'b0;
    @(negedge clk) start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  function automatic int exp_rises(input int lc, input bit mir);
    if (mir) return 24;
    return (lc == 1) ? 15 : (lc == 2) ? 14 : 16;
  endfunction

  function automatic int floor_div(input int s, input int d);
    if (s >= 0) return s / d;
    return -((-s + d - 1) / d);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(adc_cs_n === 1'b1 && adc_sclk === 1'b1, "R1 cs/sclk idle", {adc_cs_n, adc_sclk}, 3);
    check(busy === 1'b0 && res_valid === 1'b0 && mirror_err === 1'b0 && avg_valid === 1'b0,
          "R1 strobes low", {busy, res_valid, mirror_err, avg_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 start drops cs, sclk still high
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(adc_cs_n === 1'b0 && adc_sclk === 1'b1, "R2 cs falls, sclk high", {adc_cs_n, adc_sclk}, 1);
    @(negedge clk);
    check(adc_sclk === 1'b0, "R2 first edge falling", adc_sclk, 0);
    wait_idle();

    // R5/R6/R4 strided sweep plus corner codes, div 0, length 16
    for (int c = 0; c < 4096; c += 7) begin
      frame(12'(c), 1'b0, 1'b0);
      check(got_res == 12'(c), "R5 sweep result", got_res, c);
      check(cs_at_valid === 1'b1, "R6 valid with cs high", cs_at_valid, 1);
      check(rises == 16, "R4 sweep rises", rises, 16);
      check(avg_cnt > 0 && got_avg == 12'(c), "R9 k0 passthrough", got_avg, c);
    end
    begin
      logic [11:0] corners [6] = '{12'h000, 12'hFFF, 12'h7FF, 12'h800, 12'h555, 12'hAAA};
      for (int i = 0; i < 6; i++) begin
        frame(corners[i], 1'b1, 1'b0);
        check(got_res == corners[i], "R5 corner with null=1", got_res, corners[i]);
      end
    end
    frame(12'h7FF, 1'b0, 1'b0);
    check($signed(got_res) == 2047, "R5 positive full scale", $signed(got_res), 2047);
    frame(12'h800, 1'b0, 1'b0);
    check($signed(got_res) == -2048, "R5 negative full scale", $signed(got_res), -2048);

    // R3/R4 divider and length codes
    for (int d = 0; d < 4; d++) begin
      for (int lc = 0; lc < 4; lc++) begin
        cfg_half_div = 8'(d); cfg_len = 2'(lc);
        frame(12'h3C5, 1'b0, 1'b0);
        check(rises == exp_rises(lc, 1'b0), "R4 rises per length code", rises, exp_rises(lc, 1'b0));
        check(clow == (2 * exp_rises(lc, 1'b0) + 1) * (d + 1), "R3 cs low time",
              clow, (2 * exp_rises(lc, 1'b0) + 1) * (d + 1));
        check(got_res == 12'h3C5, "R5 result at length", got_res, 12'h3C5);
      end
    end

    // R7 no extra frame after held start
    cfg_half_div = 8'd2; cfg_len = 2'd0;
    frame(12'h123, 1'b0, 1'b0);
    rises = 0;
    repeat (40) @(negedge clk);
    check(rises == 0 && adc_cs_n === 1'b1, "R7 no second frame", rises, 0);
    // R7 gap between back-to-back frames
    res_seen = 1'b0;
    @(negedge clk) start = 1'b1;
    while (!res_seen) @(negedge clk);
    chigh = 0;
    while (adc_cs_n) @(negedge clk);
    start = 1'b0;
    check(chigh >= 2 * 3, "R7 gap length", chigh, 6);
    wait_idle();

    // R8 mirror capture
    cfg_half_div = 8'd1; cfg_mirror = 1'b1; cfg_len = 2'd2;
    frame(12'h9A6, 1'b0, 1'b0);
    check(rises == 24, "R4 mirror rises", rises, 24);
    check(clow == 49 * 2, "R3 mirror cs low time", clow, 98);
    check(got_err === 1'b0, "R8 matching copy no error", got_err, 0);
    check(got_res == 12'h9A6, "R8 result", got_res, 12'h9A6);
    frame(12'h9A6, 1'b0, 1'b1);
    check(got_err === 1'b1, "R8 corrupted copy flags error", got_err, 1);
    check(got_res == 12'h9A6, "R8 first word kept", got_res, 12'h9A6);
    cfg_mirror = 1'b0;
    frame(12'h9A6, 1'b0, 1'b1);
    check(got_err === 1'b0, "R8 error only in mirror mode", got_err, 0);

    // R9 averager
    cfg_half_div = 8'd0;
    for (int k = 1; k <= 5; k++) begin
      int n, sum, base;
      n = (k > 4) ? 16 : (1 << k);
      cfg_avg_log2 = (k == 5) ? 3'd7 : 3'(k);
      sum = 0;
      for (int j = 0; j < n; j++) begin
        int v;
        v = (j * 611 + k * 97) % 4096 - 2048;
        sum += v;
        base = avg_cnt;
        frame(12'(v), 1'b0, 1'b0);
        if (j < n - 1) check(avg_cnt == base, "R9 no mean mid-group", avg_cnt, base);
        else check(avg_cnt == base + 1, "R9 mean at group end", avg_cnt, base + 1);
      end
      check($signed(got_avg) == floor_div(sum, n), "R9 floor mean",
            $signed(got_avg), floor_div(sum, n));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule